// File: doc/BRIEF.md
# Power-Switch SPI Command and Diagnosis Slave

This block is the serial control port of a dual-channel power-switch controller. A host sends one 8-bit command per chip-select frame. The block decodes the command into channel on/off states, a mode nibble and the function of the shared serial-output pin. In the same frame it shifts out a diagnosis byte, which it captured when chip select went low. Fault inputs from the chip set sticky bits in the diagnosis register. A frame that carries a valid command clears those bits when chip select rises.

The chip-select, serial-clock and serial-data pins are brought into the system clock domain through two-flop synchronizers, and all edges are detected there. The serial-output pin starts up as a status output that mirrors the channel-2 status signal. A configuration command turns it into the SPI data output, whose enable is released while chip select is high. An external pad cell combines the data and enable outputs into a tri-state pin.

Top module: `pwrsw_spi_diag`

## Requirements
- R1: A frame carries 8 bits, MSB first, on both SI and SO. SI is sampled on the SCLK falling edge, and SO moves to its next bit after the SCLK rising edge. Outside sleep mode, the bits read from SO in a frame are the diagnosis register as it stood at the falling edge of CS.
- R2: While CS is high, SCLK and SI have no effect: the shift register and the bit count keep their values.
- R3: With sleep_i high at the falling edge of CS, the diagnosis is not copied. SO then shifts out the shift register's previous contents, which are the last byte received.
- R4: In SPI output mode, so_en is low while CS is high and high while CS is low.
- R5: A valid command 0001_xxxx loads chan_on[0] (channel 1) from bit 0 and chan_on[1] (channel 2) from bit 1.
- R6: At the rising edge of CS after a valid command, the diagnosis register is cleared. A fault input active in that same cycle leaves its bit set.
- R7: A frame is invalid if it has a number of SCLK falling edges other than 8, or an upper nibble other than 0000, 0001, 0010 or 0111. An invalid frame changes no control output and does not clear the diagnosis.
- R8: After reset, chan_on and mode_q are 0, so_en is 1 and so_out follows ch2_stat_i. A valid command 0111_xxxx switches the pin to SPI output mode (so_spi=1), and the pin stays in that mode until reset.
- R9: A high level on fault_i[i] sets diagnosis bit i, and the bit stays set until a valid-command clear.
- R10: A valid command 0010_xxxx loads mode_q from bits 3:0. The command 0000_xxxx is a valid no-operation that only clears the diagnosis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| sleep_i | input | 1 | Sleep mode; suppresses the diagnosis capture |
| ch2_stat_i | input | 1 | Channel-2 status, routed to the pin in status mode |
| fault_i | input | 8 | Fault events, one per diagnosis bit |
| so_out | output | 1 | Data for the shared output pin |
| so_en | output | 1 | Output enable for the shared pin |
| chan_on | output | 2 | Channel on states (bit 0 = channel 1) |
| mode_q | output | 4 | Mode nibble register |
| so_spi | output | 1 | 1 when the pin is the SPI data output |

## Verification
A wrong bit count or a wrong shift-register state shows up in one of two ways: a command that should apply does not, or an invalid one does. The control outputs reveal this within three clock cycles of the CS rising edge. A diagnosis register that clears when it should not, or fails to keep a fault, stays hidden until the next frame. It then appears bit by bit on SO, MSB first. A gating fault during CS-high clocking is also hidden at first. It is exposed by a following sleep-mode frame, which shifts out the untouched shift register.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int FRAME_W = 8;
  localparam int NIB_W   = FRAME_W / 2;

  typedef enum logic [2:0] {
    K_NOP   = 3'd0,
    K_CHAN  = 3'd1,
    K_MODE  = 3'd2,
    K_IOCFG = 3'd3,
    K_BAD   = 3'd4
  } cmd_kind_e;

  // Upper nibble selects the command class.
  function automatic cmd_kind_e cmd_kind_f(input logic [FRAME_W-1:0] b);
    case (b[FRAME_W-1 -: NIB_W])
      4'b0000: return K_NOP;
      4'b0001: return K_CHAN;
      4'b0010: return K_MODE;
      4'b0111: return K_IOCFG;
      default: return K_BAD;
    endcase
  endfunction

  // Sticky diagnosis: a clear wipes old bits, new faults always land.
  function automatic logic [FRAME_W-1:0] nxt_diag_f(input logic [FRAME_W-1:0] cur,
                                                    input logic [FRAME_W-1:0] flt,
                                                    input logic               clr);
    return (clr ? '0 : cur) | flt;
  endfunction
endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int          N   = 3,
  parameter logic [2:0]  RST = 3'b001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dsync,
  output logic [N-1:0] dprev
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST[i];
        sync_q <= RST[i];
        prev_q <= RST[i];
      end else begin
        meta_q <= din[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign dsync[i] = sync_q;
    assign dprev[i] = prev_q;
  end
endmodule

// File: rtl/pss_shifter.sv
module pss_shifter #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_fall,
  input  logic          sclk_fall,
  input  logic          sclk_rise,
  input  logic          sdi_s,
  input  logic          sleep_i,
  input  logic [W-1:0]  diag_q,
  output logic [W-1:0]  sh_q,
  output logic [CW-1:0] bit_cnt,
  output logic          so_bit
);
  localparam logic [CW-1:0] CNT_SAT = CW'(W + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      bit_cnt <= '0;
      so_bit  <= 1'b0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
      if (!sleep_i) begin
        sh_q   <= diag_q;
        so_bit <= diag_q[W-1];
      end else begin
        so_bit <= sh_q[W-1];
      end
    end else begin
      if (sclk_fall) begin
        sh_q <= {sh_q[W-2:0], sdi_s};
        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
      end
      if (sclk_rise) so_bit <= sh_q[W-1];
    end
  end
endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
#(
  parameter int W   = FRAME_W,
  parameter int NCH = 2,
  parameter int CW  = $clog2(W + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_rise,
  input  logic [W-1:0]   rx_byte,
  input  logic [CW-1:0]  bit_cnt,
  input  logic [W-1:0]   fault_i,
  output logic           apply_ok,
  output logic [W-1:0]   diag_q,
  output logic [NCH-1:0] chan_on,
  output logic [NIB_W-1:0] mode_q,
  output logic           so_spi
);
  cmd_kind_e kind;
  logic      frame_full;

  assign kind       = cmd_kind_f(rx_byte);
  assign frame_full = (bit_cnt == CW'(W));
  assign apply_ok   = cs_rise && frame_full && (kind != K_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diag_q <= '0;
      mode_q <= '0;
      so_spi <= 1'b0;
    end else begin
      diag_q <= nxt_diag_f(diag_q, fault_i, apply_ok);
      if (apply_ok && kind == K_MODE)  mode_q <= rx_byte[NIB_W-1:0];
      if (apply_ok && kind == K_IOCFG) so_spi <= 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           chan_on[c] <= 1'b0;
      else if (apply_ok && kind == K_CHAN)  chan_on[c] <= rx_byte[c];
    end
  end
endmodule

// File: rtl/pwrsw_spi_diag.sv
module pwrsw_spi_diag
  import pss_pkg::*;
#(
  parameter int W   = FRAME_W,
  parameter int NCH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdi,
  input  logic             sleep_i,
  input  logic             ch2_stat_i,
  input  logic [W-1:0]     fault_i,
  output logic             so_out,
  output logic             so_en,
  output logic [NCH-1:0]   chan_on,
  output logic [NIB_W-1:0] mode_q,
  output logic             so_spi
);
  localparam int CW = $clog2(W + 2);

  logic [2:0]    pin_s, pin_p;
  logic          cs_sync, cs_fall, cs_rise, sclk_fall, sclk_rise;
  logic [W-1:0]  sh_q, diag_q;
  logic [CW-1:0] bit_cnt;
  logic          so_bit, apply_ok;

  pss_sync #(.N(3), .RST(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sdi, sclk, cs_n}),
    .dsync(pin_s), .dprev(pin_p)
  );

  assign cs_sync   = pin_s[0];
  assign cs_fall   =  pin_p[0] && !pin_s[0];
  assign cs_rise   = !pin_p[0] &&  pin_s[0];
  assign sclk_fall = !cs_sync &&  pin_p[1] && !pin_s[1];
  assign sclk_rise = !cs_sync && !pin_p[1] &&  pin_s[1];

  pss_shifter #(.W(W), .CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .sclk_fall(sclk_fall),
    .sclk_rise(sclk_rise), .sdi_s(pin_s[2]), .sleep_i(sleep_i),
    .diag_q(diag_q), .sh_q(sh_q), .bit_cnt(bit_cnt), .so_bit(so_bit)
  );

  pss_ctrl #(.W(W), .NCH(NCH), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .rx_byte(sh_q),
    .bit_cnt(bit_cnt), .fault_i(fault_i), .apply_ok(apply_ok),
    .diag_q(diag_q), .chan_on(chan_on), .mode_q(mode_q), .so_spi(so_spi)
  );

  assign so_en  = !so_spi || !cs_sync;
  assign so_out = so_spi ? so_bit : ch2_stat_i;
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int W   = 8,
  parameter int NCH = 2,
  parameter int CW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cs_sync,
  input logic           cs_rise,
  input logic           apply_ok,
  input logic [W-1:0]   diag_q,
  input logic [W-1:0]   fault_i,
  input logic [CW-1:0]  bit_cnt,
  input logic [NCH-1:0] chan_on,
  input logic [3:0]     mode_q,
  input logic           so_spi,
  input logic           so_en,
  input logic           so_out,
  input logic           ch2_stat_i
);
  AST_CLEAR_KEEPS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    apply_ok |=> diag_q == $past(fault_i)); // R6
  AST_DIAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_ok |=> (diag_q & $past(diag_q)) == $past(diag_q)); // R9
  AST_HOLD_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_ok |=> $stable(chan_on) && $stable(mode_q) && $stable(so_spi)); // R7
  AST_APPLY_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    apply_ok |-> cs_rise && bit_cnt == CW'(W)); // R7
  AST_CNT_FROZEN_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_sync |=> $stable(bit_cnt)); // R2
  AST_STATUS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    !so_spi |-> so_en && so_out == ch2_stat_i); // R8
  AST_SPI_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    so_spi |=> so_spi); // R8
  AST_SO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (so_spi && cs_sync) |-> !so_en); // R4
endmodule

bind pwrsw_spi_diag pss_checker #(.W(W), .NCH(NCH), .CW(CW)) u_pss_chk (
  .clk(clk), .rst_n(rst_n), .cs_sync(cs_sync), .cs_rise(cs_rise),
  .apply_ok(apply_ok), .diag_q(diag_q), .fault_i(fault_i), .bit_cnt(bit_cnt),
  .chan_on(chan_on), .mode_q(mode_q), .so_spi(so_spi), .so_en(so_en),
  .so_out(so_out), .ch2_stat_i(ch2_stat_i)
);

// File: tb/pwrsw_spi_diag_bench.sv
module pwrsw_spi_diag_bench;
  localparam int HW = 6;
  // [36] sleep [35:28] fault [27:20] cmd [19:16] nbits [15] chk_so
  // [14:7] exp_so [6:5] exp_chan [4:1] exp_mode [0] exp_spi
  localparam logic [36:0] VEC [0:9] = '{
    {1'b0, 8'h00, 8'h70, 4'd8, 1'b0, 8'h00, 2'd0, 4'h0, 1'b1},
    {1'b0, 8'h05, 8'h13, 4'd8, 1'b1, 8'h05, 2'd3, 4'h0, 1'b1},
    {1'b0, 8'h80, 8'h55, 4'd8, 1'b1, 8'h80, 2'd3, 4'h0, 1'b1},
    {1'b0, 8'h01, 8'h12, 4'd7, 1'b1, 8'h81, 2'd3, 4'h0, 1'b1},
    {1'b0, 8'h00, 8'h2A, 4'd8, 1'b1, 8'h81, 2'd3, 4'hA, 1'b1},
    {1'b0, 8'h40, 8'h01, 4'd9, 1'b1, 8'h40, 2'd3, 4'hA, 1'b1},
    {1'b0, 8'h00, 8'h00, 4'd8, 1'b1, 8'h40, 2'd3, 4'hA, 1'b1},
    {1'b1, 8'h10, 8'h11, 4'd8, 1'b1, 8'h00, 2'd1, 4'hA, 1'b1},
    {1'b0, 8'h22, 8'h12, 4'd8, 1'b1, 8'h22, 2'd2, 4'hA, 1'b1},
    {1'b0, 8'h00, 8'h9F, 4'd8, 1'b1, 8'h00, 2'd2, 4'hA, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, sleep_i = 1'b0, ch2_stat_i = 1'b0;
  logic [7:0] fault_i = '0;
  logic so_out, so_en, so_spi;
  logic [1:0] chan_on;
  logic [3:0] mode_q;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pwrsw_spi_diag u_pwrsw_spi_diag (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sleep_i(sleep_i), .ch2_stat_i(ch2_stat_i), .fault_i(fault_i),
    .so_out(so_out), .so_en(so_en), .chan_on(chan_on), .mode_q(mode_q),
    .so_spi(so_spi)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_fault(input logic [7:0] f);
    fault_i = f; wclk(2); fault_i = '0; wclk(2);
  endtask

  // One CS frame; optional fault pulse placed on the clear cycle after CS rises.
  task automatic do_frame(input logic [7:0] cmd, input int n, input logic [7:0] clr_flt,
                          input bit spi_chk, output logic [7:0] rd);
    rd = '0;
    cs_n = 1'b0; wclk(HW);
    if (spi_chk) chk(so_en === 1'b1, "R4 enable with CS low", so_en, 1);
    for (int k = 0; k < n; k++) begin
      sdi = (k < 8) ? cmd[7-k] : 1'b0;
      wclk(HW); sclk = 1'b1; wclk(HW);
      if (k < 8) rd = {rd[6:0], so_out};
      sclk = 1'b0; wclk(HW);
    end
    cs_n = 1'b1;
    if (clr_flt != 0) begin
      wclk(2); fault_i = clr_flt; wclk(1); fault_i = '0;
    end
    wclk(HW);
    if (spi_chk) chk(so_en === 1'b0, "R4 release with CS high", so_en, 0);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] rd, expv;
    wclk(3); rst_n = 1'b1; wclk(3);
    // R8 reset state and status-mode pin
    chk(chan_on == 0 && mode_q == 0 && so_spi == 0, "R8 reset regs", {chan_on, mode_q, so_spi}, 0);
    chk(so_en == 1 && so_out == 0, "R8 status pin low", {so_en, so_out}, 2'b10);
    ch2_stat_i = 1'b1; wclk(1);
    chk(so_en == 1 && so_out == 1, "R8 status pin high", {so_en, so_out}, 2'b11);
    ch2_stat_i = 1'b0;

    for (int v = 0; v < 10; v++) begin
      logic [36:0] e;
      e = VEC[v];
      sleep_i = e[36];
      pulse_fault(e[35:28]);
      do_frame(e[27:20], int'(e[19:16]), 8'h00, so_spi, rd);
      sleep_i = 1'b0;
      if (e[15]) begin
        expv = (e[19:16] < 8) ? (e[14:7] >> (8 - e[19:16])) : e[14:7];
        chk(rd == expv, e[36] ? "R3 sleep readout" : "R1_R6_R9 diag readout", rd, expv);
      end
      chk(chan_on == e[6:5], "R5_R7 channel states", chan_on, e[6:5]);
      chk(mode_q == e[4:1], "R10_R7 mode nibble", mode_q, e[4:1]);
      chk(so_spi == e[0], "R8 pin mode", so_spi, e[0]);
    end

    // R2: clocking with CS high must not touch the shift register.
    do_frame(8'h13, 8, 8'h00, 1'b1, rd);
    chk(chan_on == 2'd3, "R5 channel both on", chan_on, 3);
    sdi = 1'b1;
    for (int k = 0; k < 8; k++) begin
      sclk = 1'b1; wclk(HW); sclk = 1'b0; wclk(HW);
    end
    sdi = 1'b0;
    chk(chan_on == 2'd3, "R2 outputs kept with CS high", chan_on, 3);
    sleep_i = 1'b1;
    do_frame(8'h00, 8, 8'h00, 1'b1, rd);
    sleep_i = 1'b0;
    chk(rd == 8'h13, "R2 shifter untouched with CS high", rd, 8'h13);

    // R6: fault landing exactly on the clear cycle survives.
    do_frame(8'h00, 8, 8'h08, 1'b1, rd);
    chk(rd == 8'h00, "R6 diag empty before", rd, 0);
    do_frame(8'h00, 8, 8'h00, 1'b1, rd);
    chk(rd == 8'h08, "R6 fault on clear cycle kept", rd, 8'h08);
    do_frame(8'h00, 8, 8'h00, 1'b1, rd);
    chk(rd == 8'h00, "R6 cleared by valid command", rd, 0);

    // R9: repeated invalid frames keep a sticky fault.
    pulse_fault(8'h04);
    do_frame(8'hF0, 8, 8'h00, 1'b1, rd);
    do_frame(8'h30, 8, 8'h00, 1'b1, rd);
    chk(rd == 8'h04, "R9 sticky across invalid frames", rd, 8'h04);

    finish_run();
  end
endmodule